// File: doc/BRIEF.md
# Dual-Direction Storing Bus Transceiver

The block connects two 18-bit ports, A and B. Each direction has its own storage stage. A separate latch-enable, strobe and output-enable control each stage, so a word can be passed through at once, held, or captured on a strobe edge and presented later. The ports are split into separate input, output and drive-enable signals, so the block can be synthesized: a deasserted drive-enable stands for a high-impedance port.

Each port input also has a keeper. A per-port valid flag marks whether the input is being driven. While the flag is low, the datapath sees the last word that arrived with the flag high, not the floating input.

All logic runs on one system clock. The direction strobes `ab_stb` and `ba_stb` are sampled on that clock. A strobe counts as rising when it is sampled high one cycle after it was sampled low. The reset is asynchronous and active low, and its release is synchronized to the system clock.

Top module: `xcvr18_bidir`

## Requirements
- R1: While reset is asserted, and after release until a word is stored, both drive-enables are low during reset and both stored words read as zero.
- R2: While `ab_le` is high, `b_out` equals the effective A word in the same cycle, whatever `ab_stb` does.
- R3: While `ab_le` is low and `ab_stb` shows no rising edge, `b_out` keeps its value across clock cycles, whether the strobe sits high or low.
- R4: While `ab_le` is low, a rising edge of `ab_stb` stores the effective A word sampled at that clock edge, and `b_out` shows it from the next cycle.
- R5: After reset, `b_drv` equals `ab_oe` and `a_drv` equals `ba_oe`. Both enables are active high.
- R6: The B-to-A direction behaves like R2 to R4, using `ba_le`, `ba_stb` and `b_in`, and driving `a_out`. Activity in one direction never changes the other direction's output.
- R7: When a port's valid flag (`a_vld` or `b_vld`) is low, the effective word for that port is the last word presented with the flag high. It is zero if no such word has been presented since reset.
- R8: If the latch-enable is sampled low in the same cycle that the strobe is first sampled high, the word present at that edge is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Word arriving on port A |
| a_vld | input | 1 | Port A is being driven from outside |
| a_out | output | 18 | Word the block presents on port A |
| a_drv | output | 1 | Block drives port A (low = high impedance) |
| b_in | input | 18 | Word arriving on port B |
| b_vld | input | 1 | Port B is being driven from outside |
| b_out | output | 18 | Word the block presents on port B |
| b_drv | output | 1 | Block drives port B (low = high impedance) |
| ab_le | input | 1 | A-to-B pass-through enable |
| ab_stb | input | 1 | A-to-B capture strobe |
| ab_oe | input | 1 | A-to-B output enable |
| ba_le | input | 1 | B-to-A pass-through enable |
| ba_stb | input | 1 | B-to-A capture strobe |
| ba_oe | input | 1 | B-to-A output enable |

## Verification
Two functions can land in the same clock edge: the latch-enable closing the pass-through window, and a rising strobe asking for a capture. The bench provokes this by dropping `ab_le` and raising `ab_stb` in the same cycle. It changes the A word at that cycle too, so the word seen at the edge differs from the one that came before and the one that comes after. The check passes only if `b_out` then shows the word present at that edge. The bench also drops the B valid flag during a strobe, to show that the keeper's word, not the floating input, is what gets captured.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned NUM_DIR = 2;
  typedef enum logic {DIR_AB = 1'b0, DIR_BA = 1'b1} xcvr_dir_e;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_ok,
  input  logic [W-1:0] din,
  input  logic         vld,
  output logic [W-1:0] dout
);
  logic [W-1:0] keep_q;
  logic [W-1:0] keep_d;
  logic         keep_en;

  always_comb begin
    keep_en = vld;
    keep_d  = din;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)      keep_q <= '0;
    else if (keep_en) keep_q <= keep_d;
  end

  // a floating input is replaced by the last driven word
  assign dout = vld ? din : keep_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_ok,
  input  logic [W-1:0] src,
  input  logic         le,
  input  logic         stb,
  input  logic         oe,
  output logic [W-1:0] dat,
  output logic         drv
);
  logic         stb_q;
  logic [W-1:0] store_q;
  logic [W-1:0] store_d;
  logic         store_en;
  logic         stb_rise;

  always_comb begin
    stb_rise = stb & ~stb_q;
    // open window tracks the source; closed window captures on a rising strobe
    store_en = le | stb_rise;
    store_d  = src;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) stb_q <= 1'b0;
    else         stb_q <= stb;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)       store_q <= '0;
    else if (store_en) store_q <= store_d;
  end

  assign dat = le ? src : store_q;
  assign drv = oe & rst_ok;
endmodule

// File: rtl/xcvr18_bidir.sv
module xcvr18_bidir
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_vld,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b_in,
  input  logic         b_vld,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  input  logic         ab_le,
  input  logic         ab_stb,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_stb,
  input  logic         ba_oe
);
  logic         rst_ok;
  logic [W-1:0] port_in  [NUM_DIR];
  logic         port_vld [NUM_DIR];
  logic [W-1:0] port_eff [NUM_DIR];
  logic [W-1:0] lane_dat [NUM_DIR];
  logic         lane_drv [NUM_DIR];
  logic         lane_le  [NUM_DIR];
  logic         lane_stb [NUM_DIR];
  logic         lane_oe  [NUM_DIR];
  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  // index DIR_AB sources from port A, DIR_BA from port B
  assign port_in[DIR_AB]  = a_in;
  assign port_vld[DIR_AB] = a_vld;
  assign port_in[DIR_BA]  = b_in;
  assign port_vld[DIR_BA] = b_vld;
  assign lane_le[DIR_AB]  = ab_le;
  assign lane_stb[DIR_AB] = ab_stb;
  assign lane_oe[DIR_AB]  = ab_oe;
  assign lane_le[DIR_BA]  = ba_le;
  assign lane_stb[DIR_BA] = ba_stb;
  assign lane_oe[DIR_BA]  = ba_oe;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_keeper #(.W(W)) u_keep (
      .clk(clk), .rst_ok(rst_ok),
      .din(port_in[d]), .vld(port_vld[d]), .dout(port_eff[d])
    );
    xcvr_lane #(.W(W)) u_lane (
      .clk(clk), .rst_ok(rst_ok), .src(port_eff[d]),
      .le(lane_le[d]), .stb(lane_stb[d]), .oe(lane_oe[d]),
      .dat(lane_dat[d]), .drv(lane_drv[d])
    );
  end

  assign a_eff = port_eff[DIR_AB];
  assign b_eff = port_eff[DIR_BA];
  assign b_out = lane_dat[DIR_AB];
  assign b_drv = lane_drv[DIR_AB];
  assign a_out = lane_dat[DIR_BA];
  assign a_drv = lane_drv[DIR_BA];
endmodule

// File: rtl/xcvr18_bidir_chk.sv
module xcvr18_bidir_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_ok,
  input logic [W-1:0] a_in,
  input logic         a_vld,
  input logic [W-1:0] a_out,
  input logic         a_drv,
  input logic [W-1:0] b_in,
  input logic         b_vld,
  input logic [W-1:0] b_out,
  input logic         b_drv,
  input logic         ab_le,
  input logic         ab_stb,
  input logic         ab_oe,
  input logic         ba_le,
  input logic         ba_stb,
  input logic         ba_oe,
  input logic [W-1:0] a_eff,
  input logic [W-1:0] b_eff
);
  logic ok_d1;
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) ok_d1 <= 1'b0;
    else         ok_d1 <= 1'b1;
  end

  always_comb begin
    if (!rst_n) assert_quiet_in_reset_R1: assert (!a_drv && !b_drv);
  end

  assert_ab_drive_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    b_drv == ab_oe);
  assert_ba_drive_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    a_drv == ba_oe);
  assert_ab_pass_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    ab_le |-> b_out == a_eff);
  assert_ba_pass_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    ba_le |-> a_out == b_eff);
  assert_ab_hold_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (ok_d1 && !ab_le && !$rose(ab_stb)) |=> (ab_le || $stable(b_out)));
  assert_ba_hold_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (ok_d1 && !ba_le && !$rose(ba_stb)) |=> (ba_le || $stable(a_out)));
  assert_ab_capture_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (ok_d1 && !ab_le && $rose(ab_stb)) |=> (ab_le || b_out == $past(a_eff)));
  assert_ab_close_edge_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (ok_d1 && $fell(ab_le) && $rose(ab_stb)) |=> (ab_le || b_out == $past(a_eff)));
  assert_a_keep_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    !a_vld |=> (a_vld || $stable(a_eff)));
  assert_b_keep_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    !b_vld |=> (b_vld || $stable(b_eff)));
endmodule

bind xcvr18_bidir xcvr18_bidir_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok),
  .a_in(a_in), .a_vld(a_vld), .a_out(a_out), .a_drv(a_drv),
  .b_in(b_in), .b_vld(b_vld), .b_out(b_out), .b_drv(b_drv),
  .ab_le(ab_le), .ab_stb(ab_stb), .ab_oe(ab_oe),
  .ba_le(ba_le), .ba_stb(ba_stb), .ba_oe(ba_oe),
  .a_eff(a_eff), .b_eff(b_eff)
);

// File: tb/xcvr18_bidir_test.sv
`timescale 1ns/1ps
module xcvr18_bidir_test;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_vld, b_vld, a_drv, b_drv;
  logic         ab_le, ab_stb, ab_oe, ba_le, ba_stb, ba_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int           sel;   // 0 b_out, 1 a_out, 2 b_drv, 3 a_drv
    logic [W-1:0] exp;
    string        req;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  xcvr18_bidir uut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_vld(a_vld), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_vld(b_vld), .b_out(b_out), .b_drv(b_drv),
    .ab_le(ab_le), .ab_stb(ab_stb), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_stb(ba_stb), .ba_oe(ba_oe)
  );

  // monitor: pops each expectation and compares it with the port it names
  initial begin
    forever begin
      item_t it;
      logic [W-1:0] act;
      wait (sbq.size() > 0);
      it = sbq.pop_front();
      case (it.sel)
        0: act = b_out;
        1: act = a_out;
        2: act = W'(b_drv);
        default: act = W'(a_drv);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_port(input int sel, input logic [W-1:0] exp, input string req);
    item_t it;
    #1;
    it.sel = sel; it.exp = exp; it.req = req;
    sbq.push_back(it);
    #0.1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; a_in = '0; b_in = '0; a_vld = 1; b_vld = 1;
    ab_le = 0; ab_stb = 0; ab_oe = 1; ba_le = 0; ba_stb = 0; ba_oe = 1;
    a_in = 18'h15555; b_in = 18'h2aaaa;
    repeat (3) step();
    expect_port(2, 0, "R1");
    expect_port(3, 0, "R1");
    rst_n = 1;
    repeat (4) step();
    expect_port(0, 0, "R1");
    expect_port(1, 0, "R1");
    expect_port(2, 1, "R5");

    // R2 pass-through
    ab_le = 1; a_in = 18'h00123;
    expect_port(0, 18'h00123, "R2");
    step(); a_in = 18'h3f00f;
    expect_port(0, 18'h3f00f, "R2");
    step(); ab_stb = 1;
    expect_port(0, 18'h3f00f, "R2");
    step(); ab_stb = 0;

    // R3 hold with strobe low
    step(); ab_le = 0; a_in = 18'h11111;
    expect_port(0, 18'h3f00f, "R3");
    step(); step();
    expect_port(0, 18'h3f00f, "R3");

    // R4 capture on rising strobe, then hold while strobe high
    step(); a_in = 18'h22222; ab_stb = 1;
    step(); a_in = 18'h33333;
    expect_port(0, 18'h22222, "R4");
    step();
    expect_port(0, 18'h22222, "R3");
    step(); ab_stb = 0;
    expect_port(0, 18'h22222, "R3");

    // R5 output enable
    step(); ab_oe = 0; ba_oe = 0;
    expect_port(2, 0, "R5");
    expect_port(3, 0, "R5");
    step(); ab_oe = 1;
    expect_port(2, 1, "R5");
    ba_oe = 1;

    // R7 keeper on port B with pass-through
    step(); ba_le = 1; b_in = 18'h0abcd; b_vld = 1;
    expect_port(1, 18'h0abcd, "R6");
    step(); b_vld = 0; b_in = 18'h3ffff;
    expect_port(1, 18'h0abcd, "R7");
    step(); b_vld = 1; b_in = 18'h01010;
    expect_port(1, 18'h01010, "R7");

    // R6 B-to-A capture, A-to-B untouched; strobe while B floats
    step(); ba_le = 0; b_vld = 0; b_in = 18'h3c3c3; ba_stb = 1;
    step(); b_vld = 1; b_in = 18'h00777;
    expect_port(1, 18'h01010, "R7");
    expect_port(0, 18'h22222, "R6");
    step(); ba_stb = 0;
    step(); ba_stb = 1;
    step(); b_in = 18'h12345;
    expect_port(1, 18'h00777, "R6");
    expect_port(0, 18'h22222, "R6");
    ba_stb = 0;

    // R8 latch-enable closes on the same edge the strobe rises
    step(); ab_le = 1; a_in = 18'h06060;
    step(); ab_le = 0; ab_stb = 1; a_in = 18'h07070;
    step(); a_in = 18'h08080;
    expect_port(0, 18'h07070, "R8");
    ab_stb = 0;
    step(); step();
    expect_port(0, 18'h07070, "R3");

    step();
    wait (sbq.size() == 0);
    #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule